// File: doc/BRIEF.md
# Core-Other Register Window Redirector

This block sits in front of a 32 KiB memory-mapped control-register space and decides where each register request goes. The space has four 8 KiB quarters: a shared global block, a block local to the requesting core, a redirect window, and a debug quarter. Requests to the global and local quarters are forwarded as they are. Requests to the redirect window are forwarded to whichever target the requester has programmed: a cluster, a core, a virtual-processor (VP) index and a block kind.

Each requester owns a private redirect selector register. The selector is reached through its own local block at offset 0x018, and the block serves that offset itself. The selector also carries two enables: one allows a cluster other than the requester's own, and one steers redirected traffic to the interrupt controller. A core number of 32 names the register manager's own block rather than a processor core.

The debug quarter and every address at or above 0x8000 act as a sink. Requests there are never forwarded. Every request produces exactly one result one clock later: either a downstream forward, or a local response carrying read data.

Top module: `corewin_redirect`

## Requirements
- R1: After reset no output is valid, and every requester's selector holds zero: core 0, VP 0, kind local, both enables clear.
- R2: A request to 0x0000–0x1FFF is forwarded on the next cycle with region code 0, offset = address bits 12:0, and all target fields, the manager flag and both enables at zero.
- R3: A request to 0x2000–0x3FFF at any offset other than 0x018 is forwarded with region code 1, the offset from address bits 12:0, and zero target fields.
- R4: A request to local offset 0x018 (address 0x2018) is answered by the block and not forwarded; the answer is a response on the next cycle. A write stores the requester's selector and returns read data 0. A read returns the stored selector. Selector bit 31 is the cluster enable, bit 30 the interrupt-controller enable, bits 25:24 the kind, bits 21:16 the cluster, bits 13:8 the core and bits 2:0 the VP. All other bits are stored as zero.
- R5: A request to 0x4000–0x5FFF is forwarded with region code 2, offset = address bits 12:0 unchanged, and core, VP and kind (0 local, 1 global, 2 user, 3 high global) taken from the requester's selector.
- R6: On a redirected forward, `dn_to_mgr` is 1 exactly when the selector's core field is 32.
- R7: On a redirected forward, `dn_cluster_en` and `dn_gic_en` copy selector bits 31 and 30. `dn_cluster` carries the selector's cluster field only when bit 31 is set, and reads zero otherwise.
- R8: Selectors are independent per requester: writing one requester's selector does not change the translation of any other requester.
- R9: A request to 0x6000–0x7FFF, or to any address at or above 0x8000 (including the alias 0xA018), is not forwarded. It returns read data 0, and a write there changes no selector.
- R10: Each accepted request yields exactly one of `dn_valid` or `rsp_valid` on the next cycle. The two are never high together, and neither is high in the cycle after a clock with no request.
- R11: A forward copies the request's write flag, write data and requester id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Byte address within the register space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_id | input | ID_W | Requester index |
| dn_valid | output | 1 | Forwarded request valid |
| dn_write | output | 1 | Forwarded write flag |
| dn_wdata | output | DATA_W | Forwarded write data |
| dn_req_id | output | ID_W | Forwarded requester index |
| dn_region | output | 2 | 0 global, 1 local, 2 redirected |
| dn_offset | output | 13 | Offset inside the selected block |
| dn_cluster | output | 6 | Target cluster (gated by cluster enable) |
| dn_core | output | 6 | Target core |
| dn_vp | output | 3 | Target VP index |
| dn_kind | output | 2 | Target block kind |
| dn_to_mgr | output | 1 | Target is the manager's own block |
| dn_cluster_en | output | 1 | Cross-cluster redirection enabled |
| dn_gic_en | output | 1 | Redirection to the interrupt controller |
| rsp_valid | output | 1 | Local response valid |
| rsp_rdata | output | DATA_W | Local response read data |

## Verification
Two functions share one clock edge: a selector write commits at the same edge that issues its response. A window access presented in the very next cycle must already be translated with the new value. The bench provokes this by writing a selector and then, with no idle cycle, issuing a window access from the same requester. It judges the result by the target fields on the forward that follows, and then reads the selector back. The vector table also interleaves requesters, so a stale or shared selector shows up as wrong target fields.

// File: rtl/corewin_pkg.sv
package corewin_pkg;

   localparam int SPACE_W   = 15;   // 32 KiB register space
   localparam int OFS_W     = 13;   // 8 KiB per quarter
   localparam int REG_W     = 32;
   localparam int CLUSTER_W = 6;
   localparam int CORE_W    = 6;
   localparam int VP_W      = 3;
   localparam int KIND_W    = 2;
   localparam logic [CORE_W-1:0] MGR_CORE = CORE_W'(32);

   typedef enum logic [1:0] {
      RG_GLOBAL = 2'd0,
      RG_LOCAL  = 2'd1,
      RG_OTHER  = 2'd2,
      RG_SINK   = 2'd3
   } region_e;

   typedef struct packed {
      logic                 cl_en;
      logic                 gic_en;
      logic [KIND_W-1:0]    kind;
      logic [CLUSTER_W-1:0] cluster;
      logic [CORE_W-1:0]    core;
      logic [VP_W-1:0]      vp;
   } sel_t;

   typedef struct packed {
      logic [1:0]       region;
      logic [OFS_W-1:0] offset;
      sel_t             tgt;
      logic             to_mgr;
   } fwd_t;

   function automatic sel_t sel_from_word(input logic [REG_W-1:0] w);
      sel_t s;
      s.cl_en   = w[31];
      s.gic_en  = w[30];
      s.kind    = w[25:24];
      s.cluster = w[21:16];
      s.core    = w[13:8];
      s.vp      = w[2:0];
      return s;
   endfunction

   function automatic logic [REG_W-1:0] sel_to_word(input sel_t s);
      logic [REG_W-1:0] w;
      w         = '0;
      w[31]     = s.cl_en;
      w[30]     = s.gic_en;
      w[25:24]  = s.kind;
      w[21:16]  = s.cluster;
      w[13:8]   = s.core;
      w[2:0]    = s.vp;
      return w;
   endfunction

endpackage

// File: rtl/corewin_decode.sv
module corewin_decode
   import corewin_pkg::*;
#(
   parameter int               ADDR_W  = 16,
   parameter logic [OFS_W-1:0] SEL_OFS = OFS_W'(12'h018)
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic [OFS_W-1:0]  offset,
   output logic              is_sel
);

   logic above_space;

   generate
      if (ADDR_W > SPACE_W) begin : g_wide
         assign above_space = |addr[ADDR_W-1:SPACE_W];
      end else begin : g_exact
         assign above_space = 1'b0;
      end
   endgenerate

   always_comb begin
      offset = addr[OFS_W-1:0];
      if (above_space) begin
         region = RG_SINK;
      end else begin
         case (addr[SPACE_W-1:OFS_W])
            2'd0:    region = RG_GLOBAL;
            2'd1:    region = RG_LOCAL;
            2'd2:    region = RG_OTHER;
            default: region = RG_SINK;
         endcase
      end
      is_sel = (region == RG_LOCAL) && (offset == SEL_OFS);
   end

endmodule

// File: rtl/corewin_sel_bank.sv
module corewin_sel_bank
   import corewin_pkg::*;
#(
   parameter int N_REQ = 4,
   parameter int ID_W  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [ID_W-1:0] wr_id,
   input  sel_t            wr_sel,
   input  logic [ID_W-1:0] rd_id,
   output sel_t            rd_sel
);

   sel_t regs [N_REQ];

   always_ff @(posedge clk) begin
      for (int i = 0; i < N_REQ; i++) begin
         if (!rst_n)
            regs[i] <= '0;
         else if (wr_en && (wr_id == ID_W'(i)))
            regs[i] <= wr_sel;
      end
   end

   always_comb begin
      rd_sel = '0;
      for (int i = 0; i < N_REQ; i++) begin
         if (rd_id == ID_W'(i))
            rd_sel = regs[i];
      end
   end

endmodule

// File: rtl/corewin_out_stage.sv
module corewin_out_stage
   import corewin_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ID_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dn_v_d,
   input  logic              rsp_v_d,
   input  logic              write_d,
   input  logic [DATA_W-1:0] wdata_d,
   input  logic [ID_W-1:0]   id_d,
   input  fwd_t              fwd_d,
   input  logic [DATA_W-1:0] rdata_d,
   output logic              dn_v_q,
   output logic              rsp_v_q,
   output logic              write_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [ID_W-1:0]   id_q,
   output fwd_t              fwd_q,
   output logic [DATA_W-1:0] rdata_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dn_v_q  <= 1'b0;
         rsp_v_q <= 1'b0;
         write_q <= 1'b0;
         wdata_q <= '0;
         id_q    <= '0;
         fwd_q   <= '0;
         rdata_q <= '0;
      end else begin
         dn_v_q  <= dn_v_d;
         rsp_v_q <= rsp_v_d;
         write_q <= write_d;
         wdata_q <= wdata_d;
         id_q    <= id_d;
         fwd_q   <= fwd_d;
         rdata_q <= rdata_d;
      end
   end

endmodule

// File: rtl/corewin_redirect.sv
module corewin_redirect
   import corewin_pkg::*;
#(
   parameter int               ADDR_W  = 16,
   parameter int               DATA_W  = 32,
   parameter int               N_REQ   = 4,
   parameter logic [OFS_W-1:0] SEL_OFS = OFS_W'(12'h018),
   localparam int              ID_W    = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic                 req_write,
   input  logic [DATA_W-1:0]    req_wdata,
   input  logic [ID_W-1:0]      req_id,
   output logic                 dn_valid,
   output logic                 dn_write,
   output logic [DATA_W-1:0]    dn_wdata,
   output logic [ID_W-1:0]      dn_req_id,
   output logic [1:0]           dn_region,
   output logic [OFS_W-1:0]     dn_offset,
   output logic [CLUSTER_W-1:0] dn_cluster,
   output logic [CORE_W-1:0]    dn_core,
   output logic [VP_W-1:0]      dn_vp,
   output logic [KIND_W-1:0]    dn_kind,
   output logic                 dn_to_mgr,
   output logic                 dn_cluster_en,
   output logic                 dn_gic_en,
   output logic                 rsp_valid,
   output logic [DATA_W-1:0]    rsp_rdata
);

   // elaboration-time parameter checks
   generate
      if (ADDR_W < SPACE_W) begin : g_bad_addr
         $error("corewin_redirect: ADDR_W must cover the 32 KiB space");
      end
      if (DATA_W < REG_W) begin : g_bad_data
         $error("corewin_redirect: DATA_W must hold a selector word");
      end
      if (N_REQ < 1) begin : g_bad_req
         $error("corewin_redirect: N_REQ must be at least 1");
      end
   endgenerate

   region_e          region;
   logic [OFS_W-1:0] offset;
   logic             is_sel;
   logic             id_ok;
   sel_t             own_sel;
   sel_t             tgt;
   fwd_t             fwd_d;
   fwd_t             fwd_q;
   logic             to_rsp;
   logic             sel_wr;
   logic [DATA_W-1:0] rdata_d;

   corewin_decode #(
      .ADDR_W (ADDR_W),
      .SEL_OFS(SEL_OFS)
   ) u_decode (
      .addr  (req_addr),
      .region(region),
      .offset(offset),
      .is_sel(is_sel)
   );

   // requester ids beyond N_REQ only exist when N_REQ is not a power of two
   generate
      if ((2 ** ID_W) > N_REQ) begin : g_partial_ids
         assign id_ok = (req_id < ID_W'(N_REQ));
      end else begin : g_full_ids
         assign id_ok = 1'b1;
      end
   endgenerate

   assign to_rsp = req_valid && ((region == RG_SINK) || is_sel);
   assign sel_wr = req_valid && is_sel && req_write && id_ok;

   corewin_sel_bank #(
      .N_REQ(N_REQ),
      .ID_W (ID_W)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (sel_wr),
      .wr_id (req_id),
      .wr_sel(sel_from_word(req_wdata[REG_W-1:0])),
      .rd_id (req_id),
      .rd_sel(own_sel)
   );

   always_comb begin
      tgt = '0;
      if (region == RG_OTHER) begin
         tgt = own_sel;
         if (!own_sel.cl_en)
            tgt.cluster = '0;
      end
      fwd_d.region = region;
      fwd_d.offset = offset;
      fwd_d.tgt    = tgt;
      fwd_d.to_mgr = (region == RG_OTHER) && (own_sel.core == MGR_CORE);

      rdata_d = '0;
      if (is_sel && !req_write && id_ok)
         rdata_d = DATA_W'(sel_to_word(own_sel));
   end

   corewin_out_stage #(
      .DATA_W(DATA_W),
      .ID_W  (ID_W)
   ) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .dn_v_d (req_valid && !to_rsp),
      .rsp_v_d(to_rsp),
      .write_d(req_write),
      .wdata_d(req_wdata),
      .id_d   (req_id),
      .fwd_d  (fwd_d),
      .rdata_d(rdata_d),
      .dn_v_q (dn_valid),
      .rsp_v_q(rsp_valid),
      .write_q(dn_write),
      .wdata_q(dn_wdata),
      .id_q   (dn_req_id),
      .fwd_q  (fwd_q),
      .rdata_q(rsp_rdata)
   );

   assign dn_region     = fwd_q.region;
   assign dn_offset     = fwd_q.offset;
   assign dn_cluster    = fwd_q.tgt.cluster;
   assign dn_core       = fwd_q.tgt.core;
   assign dn_vp         = fwd_q.tgt.vp;
   assign dn_kind       = fwd_q.tgt.kind;
   assign dn_to_mgr     = fwd_q.to_mgr;
   assign dn_cluster_en = fwd_q.tgt.cl_en;
   assign dn_gic_en     = fwd_q.tgt.gic_en;

endmodule

// File: rtl/corewin_redirect_chk.sv
module corewin_redirect_chk
   import corewin_pkg::*;
#(
   parameter int  ADDR_W = 16,
   parameter int  DATA_W = 32,
   parameter int  N_REQ  = 4,
   localparam int ID_W   = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic [ADDR_W-1:0]    req_addr,
   input logic                 req_write,
   input logic [DATA_W-1:0]    req_wdata,
   input logic [ID_W-1:0]      req_id,
   input logic                 dn_valid,
   input logic                 dn_write,
   input logic [DATA_W-1:0]    dn_wdata,
   input logic [ID_W-1:0]      dn_req_id,
   input logic [1:0]           dn_region,
   input logic [OFS_W-1:0]     dn_offset,
   input logic [CLUSTER_W-1:0] dn_cluster,
   input logic [CORE_W-1:0]    dn_core,
   input logic [VP_W-1:0]      dn_vp,
   input logic [KIND_W-1:0]    dn_kind,
   input logic                 dn_to_mgr,
   input logic                 dn_cluster_en,
   input logic                 dn_gic_en,
   input logic                 rsp_valid,
   input logic [DATA_W-1:0]    rsp_rdata
);

   p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(dn_valid && rsp_valid));

   p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (dn_valid || rsp_valid));

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!dn_valid && !rsp_valid));

   p_sink_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_addr >= ADDR_W'(16'h6000)))
      |=> (rsp_valid && !dn_valid && (rsp_rdata == '0)));

   p_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> (dn_offset == $past(req_addr[OFS_W-1:0])));

   p_mgr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && dn_to_mgr) |-> ((dn_core == MGR_CORE) && (dn_region == 2'd2)));

   p_cluster_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_cluster_en) |-> (dn_cluster == '0));

   p_plain_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && (dn_region != 2'd2))
      |-> ({dn_cluster, dn_core, dn_vp, dn_kind, dn_to_mgr, dn_cluster_en, dn_gic_en} == '0));

   p_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> ((dn_wdata == $past(req_wdata)) && (dn_write == $past(req_write))
                    && (dn_req_id == $past(req_id))));

endmodule

bind corewin_redirect corewin_redirect_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W),
   .N_REQ (N_REQ)
) u_chk (.*);

// File: tb/tb_corewin_redirect.sv
`timescale 1ns/1ps
module tb_corewin_redirect;

   localparam int ADDR_W = 16;
   localparam int DATA_W = 32;
   localparam int N_REQ  = 4;
   localparam int ID_W   = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              req_write = 1'b0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic [ID_W-1:0]   req_id = '0;
   logic              dn_valid, dn_write, dn_to_mgr, dn_cluster_en, dn_gic_en, rsp_valid;
   logic [DATA_W-1:0] dn_wdata, rsp_rdata;
   logic [ID_W-1:0]   dn_req_id;
   logic [1:0]        dn_region, dn_kind;
   logic [12:0]       dn_offset;
   logic [5:0]        dn_cluster, dn_core;
   logic [2:0]        dn_vp;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   corewin_redirect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_REQ(N_REQ)) dut (.*);

   typedef struct packed {
      logic [1:0]  id;
      logic        wr;
      logic [15:0] addr;
      logic [31:0] wdata;
      logic        fwd;
      logic [1:0]  rg;
      logic [12:0] ofs;
      logic [5:0]  cl;
      logic [5:0]  co;
      logic [2:0]  vp;
      logic [1:0]  kd;
      logic        mgr;
      logic        clen;
      logic        gien;
      logic [31:0] rd;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{2'd0,1'b0,16'h4010,32'h0,       1'b1,2'd2,13'h010, 6'd0, 6'd0, 3'd0,2'd0,1'b0,1'b0,1'b0,32'h0},
      '{2'd0,1'b1,16'h2018,32'hFFFFFFFF,1'b0,2'd0,13'h0,   6'd0, 6'd0, 3'd0,2'd0,1'b0,1'b0,1'b0,32'h0},
      '{2'd0,1'b0,16'h2018,32'h0,       1'b0,2'd0,13'h0,   6'd0, 6'd0, 3'd0,2'd0,1'b0,1'b0,1'b0,32'hC33F3F07},
      '{2'd0,1'b1,16'h5ABC,32'h12345678,1'b1,2'd2,13'h1ABC,6'd63,6'd63,3'd7,2'd3,1'b0,1'b1,1'b1,32'h0},
      '{2'd1,1'b0,16'h4004,32'h0,       1'b1,2'd2,13'h004, 6'd0, 6'd0, 3'd0,2'd0,1'b0,1'b0,1'b0,32'h0},
      '{2'd1,1'b1,16'h2018,32'h41092005,1'b0,2'd0,13'h0,   6'd0, 6'd0, 3'd0,2'd0,1'b0,1'b0,1'b0,32'h0},
      '{2'd1,1'b0,16'h4FF0,32'h0,       1'b1,2'd2,13'h0FF0,6'd0, 6'd32,3'd5,2'd1,1'b1,1'b0,1'b1,32'h0},
      '{2'd0,1'b0,16'h0030,32'h0,       1'b1,2'd0,13'h030, 6'd0, 6'd0, 3'd0,2'd0,1'b0,1'b0,1'b0,32'h0},
      '{2'd2,1'b1,16'h2020,32'h0000A5A5,1'b1,2'd1,13'h020, 6'd0, 6'd0, 3'd0,2'd0,1'b0,1'b0,1'b0,32'h0},
      '{2'd3,1'b0,16'h6000,32'h0,       1'b0,2'd0,13'h0,   6'd0, 6'd0, 3'd0,2'd0,1'b0,1'b0,1'b0,32'h0},
      '{2'd3,1'b1,16'hA018,32'hFFFFFFFF,1'b0,2'd0,13'h0,   6'd0, 6'd0, 3'd0,2'd0,1'b0,1'b0,1'b0,32'h0},
      '{2'd3,1'b0,16'h2018,32'h0,       1'b0,2'd0,13'h0,   6'd0, 6'd0, 3'd0,2'd0,1'b0,1'b0,1'b0,32'h0},
      '{2'd3,1'b1,16'h7FFC,32'hFFFFFFFF,1'b0,2'd0,13'h0,   6'd0, 6'd0, 3'd0,2'd0,1'b0,1'b0,1'b0,32'h0},
      '{2'd3,1'b0,16'h4000,32'h0,       1'b1,2'd2,13'h000, 6'd0, 6'd0, 3'd0,2'd0,1'b0,1'b0,1'b0,32'h0},
      '{2'd0,1'b0,16'h5FFF,32'h0,       1'b1,2'd2,13'h1FFF,6'd63,6'd63,3'd7,2'd3,1'b0,1'b1,1'b1,32'h0},
      '{2'd0,1'b0,16'h2019,32'h0,       1'b1,2'd1,13'h019, 6'd0, 6'd0, 3'd0,2'd0,1'b0,1'b0,1'b0,32'h0},
      '{2'd1,1'b0,16'h6018,32'h0,       1'b0,2'd0,13'h0,   6'd0, 6'd0, 3'd0,2'd0,1'b0,1'b0,1'b0,32'h0},
      '{2'd2,1'b0,16'h3FFF,32'h0,       1'b1,2'd1,13'h1FFF,6'd0, 6'd0, 3'd0,2'd0,1'b0,1'b0,1'b0,32'h0},
      '{2'd1,1'b0,16'h2018,32'h0,       1'b0,2'd0,13'h0,   6'd0, 6'd0, 3'd0,2'd0,1'b0,1'b0,1'b0,32'h41092005}
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] id, input logic wr,
                        input logic [15:0] addr, input logic [31:0] wd);
      req_valid = 1'b1;
      req_id    = id;
      req_write = wr;
      req_addr  = addr;
      req_wdata = wd;
   endtask

   task automatic idle();
      req_valid = 1'b0;
      req_write = 1'b0;
      req_addr  = '0;
      req_wdata = '0;
   endtask

   task automatic check_vec(input vec_t v);
      string rtag;
      rtag = (v.rg == 2'd0) ? "R2" : (v.rg == 2'd1) ? "R3" : "R5 R8";
      if (v.fwd) begin
         check("R10 forward only", {62'd0, dn_valid, rsp_valid}, 64'd2);
         check({rtag, " region/offset/core/vp/kind"},
               64'({dn_region, dn_offset, dn_core, dn_vp, dn_kind}),
               64'({v.rg, v.ofs, v.co, v.vp, v.kd}));
         check("R6 manager flag", 64'(dn_to_mgr), 64'(v.mgr));
         check("R7 cluster/enables", 64'({dn_cluster, dn_cluster_en, dn_gic_en}),
               64'({v.cl, v.clen, v.gien}));
         check("R11 passthrough", 64'({dn_write, dn_req_id, dn_wdata}),
               64'({v.wr, v.id, v.wdata}));
      end else begin
         check("R10 response only", {62'd0, dn_valid, rsp_valid}, 64'd1);
         if (v.addr >= 16'h6000)
            check("R9 sink read data", 64'(rsp_rdata), 64'(v.rd));
         else
            check("R4 selector data", 64'(rsp_rdata), 64'(v.rd));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs idle during and right after reset
      check("R1 reset outputs", {62'd0, dn_valid, rsp_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", {62'd0, dn_valid, rsp_valid}, 64'd0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].id, VEC[i].wr, VEC[i].addr, VEC[i].wdata);
         @(negedge clk);
         idle();
         check_vec(VEC[i]);
         @(negedge clk);
         check("R10 idle cycle", {62'd0, dn_valid, rsp_valid}, 64'd0);
      end

      // Back-to-back: selector write then window access by the same requester (R4, R5)
      drive(2'd2, 1'b1, 16'h2018, 32'h80000400);
      @(negedge clk);
      check("R4 write ack", {31'd0, rsp_valid, rsp_rdata}, {31'd0, 1'b1, 32'h0});
      drive(2'd2, 1'b0, 16'h4100, 32'h0);
      @(negedge clk);
      idle();
      check("R5 back-to-back target",
            64'({dn_valid, dn_region, dn_offset, dn_core, dn_cluster, dn_cluster_en, dn_gic_en}),
            64'({1'b1, 2'd2, 13'h100, 6'd4, 6'd0, 1'b1, 1'b0}));
      drive(2'd2, 1'b0, 16'h2018, 32'h0);
      @(negedge clk);
      idle();
      check("R4 readback", 64'(rsp_rdata), 64'h80000400);

      // R1: reset in mid-run clears the selectors
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      drive(2'd0, 1'b0, 16'h2018, 32'h0);
      @(negedge clk);
      idle();
      check("R1 selector cleared", {31'd0, rsp_valid, rsp_rdata}, {31'd0, 1'b1, 32'h0});
      drive(2'd1, 1'b0, 16'h4008, 32'h0);
      @(negedge clk);
      idle();
      check("R1 zero target after reset",
            64'({dn_valid, dn_core, dn_vp, dn_kind, dn_to_mgr, dn_gic_en}),
            64'({1'b1, 6'd0, 3'd0, 2'd0, 1'b0, 1'b0}));
      @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (100000) @(posedge clk);
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule